// File: doc/BRIEF.md
# Interrupt Status and Enable Register Set

This block is the interrupt register set of a serial peripheral controller. It watches seven event lines that come from the shift engine and the FIFOs. It latches them into a status register and compares that status against an enable mask. From the result it drives one registered interrupt line. Software sees four word offsets, and all four share one 7-bit field layout. Bit 1 is mode fault, bit 2 is transmit below watermark, bit 3 is transmit full and bit 4 is receive not empty. Bits 0, 5 and 6 are further event slots. Writing the all-events value 0x7F touches every bit.

Events come in two kinds. Edge events (bits 0, 1, 5, 6) latch on the rising edge of their input and stay set until software clears them. Level events (bits 2, 3, 4) are set again on every cycle their condition holds. A level bit therefore cannot be cleared while its condition persists. The mask has no write path of its own. A write to the enable offset adds bits to it, a write to the disable offset removes bits, and the mask offset only reads it back. Write data is the 7-bit event field. Read data is a full word with the upper bits zero.

Top module: `intr_regset`

## Requirements
- R1: A read at offset 0x04 returns the status bits in [6:0] and zero in every bit above 6.
- R2: An edge event bit (0, 1, 5, 6) becomes set in the cycle after its input rises and stays set after the input falls. A clear done while the input is still high leaves it clear until the next rising edge.
- R3: A level event bit (2, 3, 4) is set while its condition is high. A clear written while the condition is still high leaves it set, and a clear written after the condition falls removes it.
- R4: Writing to offset 0x04 clears each status bit whose data bit is 1, and leaves bits written as 0 unchanged.
- R5: Writing to offset 0x08 sets each mask bit whose data bit is 1, and leaves bits written as 0 unchanged.
- R6: Writing to offset 0x0C clears each mask bit whose data bit is 1, and leaves bits written as 0 unchanged.
- R7: After reset, status, mask and the interrupt line are all zero. A read at 0x10 returns the mask, and reads at 0x08 and 0x0C return zero.
- R8: The interrupt line is 1 exactly when, one clock earlier, some bit was set in both status and mask.
- R9: When a status clear and a new event for the same bit arrive in the same cycle, the bit ends up set.
- R10: Writes to offset 0x10 or to any offset that is not 0x04, 0x08 or 0x0C change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 7 | Write data, event field |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_in | input | 7 | Raw event lines, one per status bit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Three kinds of event input are applied: single-cycle pulses, lines held high across several cycles, and lines that rise in the same cycle as a clear write. The held-high case separates edge bits from level bits, because the two kinds disagree on whether a clear sticks. The same-cycle case shows the event taking priority over the clear. Enable and disable writes carry mixed one-and-zero patterns, so a design that loads the mask outright instead of setting or clearing bits shows up. The interrupt line is sampled on the cycle before and the cycle after each status or mask change, which pins down its single register stage.

// File: rtl/intr_regset_pkg.sv
package intr_regset_pkg;

  localparam int EVT_W = 7;
  typedef logic [EVT_W-1:0] evt_t;

  localparam int BIT_MODE_FAULT = 1;
  localparam int BIT_TX_LOW     = 2;
  localparam int BIT_TX_FULL    = 3;
  localparam int BIT_RX_AVAIL   = 4;

  localparam evt_t EVT_ALL = '1;
  localparam evt_t LEVEL_BITS = evt_t'((1 << BIT_TX_LOW) | (1 << BIT_TX_FULL) | (1 << BIT_RX_AVAIL));

  // Clear first, then set: a same-cycle event survives a clear.
  function automatic evt_t status_next(evt_t cur, evt_t clr, evt_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic evt_t mask_next(evt_t cur, evt_t add, evt_t drop);
    return (cur | add) & ~drop;
  endfunction

  function automatic logic irq_any(evt_t st, evt_t mk);
    return |(st & mk);
  endfunction

endpackage

// File: rtl/intr_evt_capture.sv
module intr_evt_capture
  import intr_regset_pkg::*;
#(
  parameter evt_t LEVEL_SEL = LEVEL_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  evt_t evt_in,
  output evt_t set_vec
);

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (LEVEL_SEL[i]) begin : g_level
      assign set_vec[i] = evt_in[i];
    end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= evt_in[i];
      end
      assign set_vec[i] = evt_in[i] & ~prev_q;
    end
  end

endmodule

// File: rtl/intr_reg_decode.sv
module intr_reg_decode
  import intr_regset_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_STATUS  = 'h04,
  parameter logic [ADDR_W-1:0] OFS_ENABLE  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_DISABLE = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_MASK    = 'h10
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  evt_t              wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  evt_t              status,
  input  evt_t              mask,
  output evt_t              stat_clr,
  output evt_t              en_set,
  output evt_t              dis_clr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - EVT_W;

  logic hit_stat, hit_en, hit_dis;

  always_comb begin
    hit_stat = wr_en && (wr_addr == OFS_STATUS);
    hit_en   = wr_en && (wr_addr == OFS_ENABLE);
    hit_dis  = wr_en && (wr_addr == OFS_DISABLE);
    stat_clr = hit_stat ? wr_data : '0;
    en_set   = hit_en   ? wr_data : '0;
    dis_clr  = hit_dis  ? wr_data : '0;
  end

  always_comb begin
    if (rd_addr == OFS_STATUS)    rd_data = {{PAD_W{1'b0}}, status};
    else if (rd_addr == OFS_MASK) rd_data = {{PAD_W{1'b0}}, mask};
    else                          rd_data = '0;
  end

endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
  import intr_regset_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t set_vec,
  input  evt_t clr_vec,
  output evt_t status_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_next(status_q, clr_vec, set_vec);
  end

endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg
  import intr_regset_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t add_vec,
  input  evt_t drop_vec,
  output evt_t mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next(mask_q, add_vec, drop_vec);
  end

endmodule

// File: rtl/intr_regset.sv
module intr_regset
  import intr_regset_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [EVT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq_o
);

  // Named internal events, visible to the bound checker.
  evt_t set_vec;
  evt_t stat_clr, en_set, dis_clr;
  evt_t status_q, mask_q;

  intr_evt_capture #(.LEVEL_SEL(LEVEL_BITS)) cap_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .set_vec(set_vec)
  );

  intr_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .status(status_q), .mask(mask_q),
    .stat_clr(stat_clr), .en_set(en_set), .dis_clr(dis_clr), .rd_data(rd_data)
  );

  intr_status_reg stat_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(stat_clr), .status_q(status_q)
  );

  intr_mask_reg mask_i (
    .clk(clk), .rst_n(rst_n), .add_vec(en_set), .drop_vec(dis_clr), .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_any(status_q, mask_q);
  end

endmodule

// File: rtl/intr_regset_chk.sv
module intr_regset_chk
  import intr_regset_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input evt_t              wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input evt_t              status,
  input evt_t              mask,
  input evt_t              set_vec,
  input logic              irq
);

  logic wr_stat, wr_en_ofs, wr_dis_ofs;
  assign wr_stat    = wr_en && (wr_addr == 8'h04);
  assign wr_en_ofs  = wr_en && (wr_addr == 8'h08);
  assign wr_dis_ofs = wr_en && (wr_addr == 8'h0C);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((status & $past(wr_data) & ~$past(set_vec)) == '0));

  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_ofs |=> ((mask & $past(wr_data)) == $past(wr_data)));

  p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis_ofs |=> ((mask & $past(wr_data)) == '0));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_ofs || wr_dis_ofs) |=> $stable(mask));

  p_irq_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & mask))));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr == 8'h08) || (rd_addr == 8'h0C)) |-> (rd_data == '0));

endmodule

bind intr_regset intr_regset_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .status(status_q), .mask(mask_q),
  .set_vec(set_vec), .irq(irq_o)
);

// File: tb/intr_regset_tb.sv
module intr_regset_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h04, A_EN = 8'h08, A_DIS = 8'h0C, A_MASK = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [6:0]  wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [6:0]  evt_in = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_regset dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Combinational read at the current negedge.
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // One write; returns at the negedge after the write edge.
  task automatic wr(logic [7:0] a, logic [6:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); check("R7 status reset", d, 0);
    rd(A_MASK, d); check("R7 mask reset", d, 0);
    rd(A_EN, d);   check("R7 enable reads zero", d, 0);
    rd(A_DIS, d);  check("R7 disable reads zero", d, 0);
    check("R7 irq reset", irq_o, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); evt_in = 7'h02;
    @(negedge clk); evt_in = 7'h00;
    rd(A_STAT, d); check("R2 edge latched", d, 32'h02);
    tick(2);
    rd(A_STAT, d); check("R2 edge sticky, R1 upper zero", d, 32'h02);
    evt_in = 7'h20;              // hold bit5 high
    tick(1);
    wr(A_STAT, 7'h22);           // clear while still high
    rd(A_STAT, d); check("R2 clear holds while input high", d, 0);
    tick(2);
    rd(A_STAT, d); check("R2 no re-set without new edge", d, 0);
    evt_in = 7'h00; tick(1);
  endtask

  task automatic t_level();
    logic [31:0] d;
    evt_in = 7'h08; tick(1);
    rd(A_STAT, d); check("R3 level set", d, 32'h08);
    wr(A_STAT, 7'h08);
    tick(1);
    rd(A_STAT, d); check("R3 level survives clear", d, 32'h08);
    evt_in = 7'h00;
    wr(A_STAT, 7'h08);
    rd(A_STAT, d); check("R3 level cleared after drop", d, 0);
  endtask

  task automatic t_clear_zero();
    logic [31:0] d;
    evt_in = 7'h42; tick(1); evt_in = 7'h00; tick(1);
    wr(A_STAT, 7'h02);
    rd(A_STAT, d); check("R4 partial clear", d, 32'h40);
    wr(A_STAT, 7'h00);
    rd(A_STAT, d); check("R4 zero write no effect", d, 32'h40);
    wr(A_MASK, 7'h7F);
    wr(8'h00, 7'h7F);
    rd(A_STAT, d); check("R10 status unchanged by other offsets", d, 32'h40);
    wr(A_STAT, 7'h7F);
    rd(A_STAT, d); check("R4 clear all", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_EN, 7'h12);  rd(A_MASK, d); check("R5 enable sets", d, 32'h12);
    wr(A_EN, 7'h40);  rd(A_MASK, d); check("R5 enable ors in", d, 32'h52);
    wr(A_EN, 7'h00);  rd(A_MASK, d); check("R5 zero enable no effect", d, 32'h52);
    wr(A_DIS, 7'h10); rd(A_MASK, d); check("R6 disable clears", d, 32'h42);
    wr(A_DIS, 7'h00); rd(A_MASK, d); check("R6 zero disable no effect", d, 32'h42);
    wr(A_MASK, 7'h7F); rd(A_MASK, d); check("R10 mask offset read-only", d, 32'h42);
    wr(8'h14, 7'h00); rd(A_MASK, d); check("R10 unknown offset ignored", d, 32'h42);
    wr(A_DIS, 7'h40); rd(A_MASK, d); check("R6 disable leaves others", d, 32'h02);
  endtask

  task automatic t_irq();
    // mask = 0x02 here
    evt_in = 7'h10; tick(1); evt_in = 7'h00;
    tick(2);
    check("R8 unmasked status gives no irq", irq_o, 0);
    wr(A_STAT, 7'h10);
    @(negedge clk); evt_in = 7'h02;
    @(negedge clk); evt_in = 7'h00;   // status set at this edge
    check("R8 irq one cycle after status", irq_o, 0);
    tick(1);
    check("R8 irq asserted", irq_o, 1);
    wr(A_DIS, 7'h02);                 // mask dropped at this edge
    check("R8 irq lags mask change", irq_o, 1);
    tick(1);
    check("R8 irq drops", irq_o, 0);
    wr(A_STAT, 7'h7F);
  endtask

  task automatic t_race();
    logic [31:0] d;
    evt_in = 7'h40; tick(1); evt_in = 7'h00; tick(1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_STAT; wr_data = 7'h40; evt_in = 7'h40;
    @(negedge clk);
    wr_en = 1'b0; evt_in = 7'h00;
    rd(A_STAT, d); check("R9 event beats clear", d, 32'h40);
    wr(A_STAT, 7'h40);
    rd(A_STAT, d); check("R9 later clear works", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_level();
    t_clear_zero();
    t_mask();
    t_irq();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule